// File: doc/BRIEF.md
# Angle Change Alert Monitor

This block watches a set of angle channels and reports which of them have drifted from a reference position by more than a programmed amount. It steps through the channels one per clock. On each step it puts the channel number on `scan_ch`, and the angle source answers in the same cycle on `ang_in`. Each channel has its own 16-bit threshold. In both the angle and the threshold, the most significant bit is worth 180°. A threshold of zero switches that channel off.

Monitoring begins when the host pulses `init_stb`. On its next visit to each channel, the block stores that channel's current angle as the channel's reference. From then on the block compares the live angle against the reference around the circle, so a move across the 0°/360° point is measured along the short way. When a channel's distance from its reference is larger than its threshold, the channel's alert bit is set. The bit stays set until the host reads it. A summary flag shows whether any alert is pending, and the interrupt output repeats that flag only while interrupts are enabled.

Top module: `angle_change_monitor`

## Requirements
- R1: After reset, `alert_bits` is 0, `chg_flag` and `irq` are low, and every threshold is 0, so no channel can raise an alert until a threshold is written.
- R2: `scan_ch` advances by one on every clock and returns to 0 after channel NCH-1.
- R3: No channel raises an alert until the first `init_stb`. Each `init_stb` makes every channel take its current angle as its new reference on its next scan.
- R4: The change is the magnitude of the 16-bit two's-complement difference (angle minus reference), which wraps around the circle. The value 8000h counts as 32768. The channel's bit is set only when the change is strictly greater than its threshold.
- R5: A channel whose threshold is 0 never raises an alert, however far its angle moves.
- R6: An alert bit stays set after the angle returns inside its threshold, and no bit clears except through a read.
- R7: A read (`rd_stb` high for one cycle) returns `alert_bits` in that cycle and clears exactly the bits returned. A bit set on the same edge is kept.
- R8: `chg_flag` is high whenever any alert bit is set. `irq` equals `chg_flag` while `irq_en` is high and is low otherwise.
- R9: A write with `thr_we` high stores `thr_data` as the threshold of channel `thr_sel`, and later comparisons for that channel use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_ch | output | CW | Channel being compared this cycle |
| ang_in | input | AW | Angle of channel `scan_ch`, MSB = 180° |
| init_stb | input | 1 | Start monitoring; recapture all references |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | CW | Channel whose threshold is written |
| thr_data | input | AW | Threshold value, MSB = 180°, 0 disables |
| irq_en | input | 1 | Lets `chg_flag` through to `irq` |
| rd_stb | input | 1 | Read of the alert register; clears the bits returned |
| alert_bits | output | NCH | Sticky per-channel alert bits |
| chg_flag | output | 1 | Any alert bit set |
| irq | output | 1 | Interrupt request |

## Verification
A stale or wrongly captured reference shows up as an alert bit for the wrong channel, or as a missing one. It appears within one full scan, NCH clocks, after the angle moves. A sign or wrap fault in the difference shows when a move crosses 0°, and an off-by-one in the comparison shows at a change exactly equal to the threshold. Both appear on `alert_bits` within the same window. A clear that drops the wrong bit shows on the next cycle after a read.

// File: rtl/angle_change_monitor.sv
module angle_change_monitor #(
  parameter int NCH = 12,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [CW-1:0]  scan_ch,
  input  logic [AW-1:0]  ang_in,
  input  logic           init_stb,
  input  logic           thr_we,
  input  logic [CW-1:0]  thr_sel,
  input  logic [AW-1:0]  thr_data,
  input  logic           irq_en,
  input  logic           rd_stb,
  output logic [NCH-1:0] alert_bits,
  output logic           chg_flag,
  output logic           irq
);

  logic [AW-1:0]  thr_r [NCH];
  logic [AW-1:0]  ref_r [NCH];
  logic [NCH-1:0] pend, armed, hit_vec, set_vec, clr_vec;

  wire [AW-1:0] diff = ang_in - ref_r[scan_ch];
  wire [AW-1:0] mag  = diff[AW-1] ? (~diff + 1'b1) : diff;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      wire sel = (scan_ch == CW'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          thr_r[g] <= '0;
          ref_r[g] <= '0;
          pend[g]  <= 1'b0;
          armed[g] <= 1'b0;
        end else begin
          if (thr_we && thr_sel == CW'(g)) thr_r[g] <= thr_data;
          if (sel && pend[g]) ref_r[g] <= ang_in;
          if (init_stb) begin
            pend[g]  <= 1'b1;
            armed[g] <= 1'b0;
          end else if (sel && pend[g]) begin
            pend[g]  <= 1'b0;
            armed[g] <= 1'b1;
          end
        end
      end

      assign hit_vec[g] = sel && armed[g] && !pend[g] &&
                          (thr_r[g] != '0) && (mag > thr_r[g]);
    end
  endgenerate

  assign set_vec = hit_vec;
  assign clr_vec = rd_stb ? alert_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_ch    <= '0;
      alert_bits <= '0;
    end else begin
      scan_ch    <= (scan_ch == CW'(NCH - 1)) ? '0 : scan_ch + 1'b1;
      alert_bits <= (alert_bits & ~clr_vec) | set_vec;
    end
  end

  assign chg_flag = |alert_bits;
  assign irq      = chg_flag & irq_en;

endmodule

// File: rtl/angle_change_monitor_chk.sv
module angle_change_monitor_chk #(
  parameter int NCH = 12,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  scan_ch,
  input logic           rd_stb,
  input logic           irq_en,
  input logic [NCH-1:0] alert_bits,
  input logic           chg_flag,
  input logic           irq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (alert_bits == '0));

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ch != CW'(NCH - 1)) |=> (scan_ch == CW'($past(scan_ch) + 1'b1)));

  // R2
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ch == CW'(NCH - 1)) |=> (scan_ch == '0));

  // R4
  set_scanned_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((alert_bits & ~$past(alert_bits) & ~(NCH'(1) << $past(scan_ch))) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (($past(alert_bits) & ~alert_bits) == '0));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((alert_bits & $past(alert_bits) & ~(NCH'(1) << $past(scan_ch))) == '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (alert_bits != '0)));

  // R8
  flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag == (alert_bits != '0));

endmodule

bind angle_change_monitor angle_change_monitor_chk #(.NCH(NCH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .scan_ch(scan_ch), .rd_stb(rd_stb), .irq_en(irq_en),
  .alert_bits(alert_bits), .chg_flag(chg_flag), .irq(irq)
);

// File: tb/test_angle_change_monitor.sv
`timescale 1ns/1ps
module test_angle_change_monitor;
  localparam int NCH = 12;
  localparam int AW  = 16;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_stb = 1'b0, thr_we = 1'b0, irq_en = 1'b0, rd_stb = 1'b0;
  logic [CW-1:0]  thr_sel = '0;
  logic [AW-1:0]  thr_data = '0;
  logic [CW-1:0]  scan_ch;
  logic [AW-1:0]  ang_in;
  logic [NCH-1:0] alert_bits;
  logic chg_flag, irq;
  logic [AW-1:0]  ang_src [NCH];
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign ang_in = ang_src[scan_ch];

  angle_change_monitor #(.NCH(NCH), .AW(AW)) i_angle_change_monitor (
    .clk(clk), .rst_n(rst_n), .scan_ch(scan_ch), .ang_in(ang_in),
    .init_stb(init_stb), .thr_we(thr_we), .thr_sel(thr_sel), .thr_data(thr_data),
    .irq_en(irq_en), .rd_stb(rd_stb), .alert_bits(alert_bits),
    .chg_flag(chg_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan();
    repeat (NCH) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_thr(input int ch, input logic [AW-1:0] v);
    @(negedge clk);
    thr_we = 1'b1; thr_sel = CW'(ch); thr_data = v;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic initiate();
    @(negedge clk);
    init_stb = 1'b1;
    @(negedge clk);
    init_stb = 1'b0;
    scan();
  endtask

  task automatic rd(output logic [NCH-1:0] v);
    @(negedge clk);
    v = alert_bits;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic prep();
    logic [NCH-1:0] dummy;
    for (int i = 0; i < NCH; i++) ang_src[i] = 16'h0000;
    for (int i = 0; i < NCH; i++) set_thr(i, 16'h0000);
    initiate();
    rd(dummy);
  endtask

  task automatic t_reset();
    chk("R1 alert_bits", 32'(alert_bits), 0);
    chk("R1 chg_flag", 32'(chg_flag), 0);
    chk("R1 irq", 32'(irq), 0);
    initiate();
    for (int i = 0; i < NCH; i++) ang_src[i] = 16'h6000;
    scan(); scan();
    chk("R1 default thresholds disabled", 32'(alert_bits), 0);
  endtask

  task automatic t_scan();
    logic [CW-1:0] prev;
    int bad = 0;
    @(negedge clk);
    prev = scan_ch;
    for (int i = 0; i < 2 * NCH; i++) begin
      @(negedge clk);
      if (scan_ch != ((prev == CW'(NCH - 1)) ? CW'(0) : CW'(prev + 1'b1))) bad++;
      prev = scan_ch;
    end
    chk("R2 round robin steps", 32'(bad), 0);
  endtask

  task automatic t_basic();
    logic [NCH-1:0] v;
    prep();
    for (int i = 0; i < NCH; i++) ang_src[i] = 16'h4000;
    set_thr(3, 16'h0100);
    initiate();
    ang_src[3] = 16'h4100;
    scan();
    chk("R4 equal to threshold no alert", 32'(alert_bits), 0);
    ang_src[3] = 16'h4101;
    scan();
    chk("R4 above threshold sets bit 3", 32'(alert_bits), 32'h008);
    chk("R8 chg_flag set", 32'(chg_flag), 1);
    rd(v);
    chk("R7 read returns bit 3", 32'(v), 32'h008);
  endtask

  task automatic t_neg();
    prep();
    ang_src[5] = 16'h1000;
    set_thr(5, 16'h0200);
    initiate();
    ang_src[5] = 16'h0E00;
    scan();
    chk("R4 negative move equal no alert", 32'(alert_bits), 0);
    ang_src[5] = 16'h0DFF;
    scan();
    chk("R4 negative move above sets bit 5", 32'(alert_bits), 32'h020);
  endtask

  task automatic t_wrap();
    prep();
    ang_src[7] = 16'hFFF0; ang_src[8] = 16'hFFF0;
    set_thr(7, 16'h0010); set_thr(8, 16'h0020);
    set_thr(9, 16'h7FFF);
    initiate();
    ang_src[7] = 16'h0001; ang_src[8] = 16'h0010; ang_src[9] = 16'h8000;
    scan();
    chk("R4 wrap and half turn", 32'(alert_bits), 32'h280);
  endtask

  task automatic t_zero();
    prep();
    initiate();
    ang_src[10] = 16'h7000;
    scan();
    chk("R5 zero threshold ignores move", 32'(alert_bits), 0);
    set_thr(10, 16'h0001);
    scan();
    chk("R9 new threshold takes effect", 32'(alert_bits), 32'h400);
  endtask

  task automatic t_no_init();
    prep();
    set_thr(1, 16'h0010);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    set_thr(1, 16'h0010);
    ang_src[1] = 16'h3000;
    scan(); scan();
    chk("R3 no alert before initiate", 32'(alert_bits), 0);
    initiate();
    ang_src[1] = 16'h3011;
    scan();
    chk("R3 reference taken at initiate", 32'(alert_bits), 32'h002);
  endtask

  task automatic t_sticky();
    logic [NCH-1:0] v;
    prep();
    set_thr(0, 16'h0040); set_thr(11, 16'h0040);
    initiate();
    ang_src[0] = 16'h0100;
    scan();
    ang_src[0] = 16'h0000;
    scan(); scan();
    chk("R6 bit held after return", 32'(alert_bits), 32'h001);
    rd(v);
    chk("R7 read value", 32'(v), 32'h001);
    chk("R7 cleared after read", 32'(alert_bits), 0);
    ang_src[11] = 16'hFF00;
    scan();
    rd(v);
    ang_src[11] = 16'h0000;
    scan();
    chk("R7 stays clear once back inside", 32'(alert_bits), 0);
  endtask

  task automatic t_irq();
    prep();
    set_thr(2, 16'h0010);
    initiate();
    ang_src[2] = 16'h0100;
    scan();
    irq_en = 1'b0; #1;
    chk("R8 irq masked", 32'(irq), 0);
    chk("R8 flag while masked", 32'(chg_flag), 1);
    irq_en = 1'b1; #1;
    chk("R8 irq enabled", 32'(irq), 1);
    irq_en = 1'b0;
  endtask

  task automatic t_reinit();
    logic [NCH-1:0] v;
    prep();
    set_thr(4, 16'h0010);
    initiate();
    ang_src[4] = 16'h2000;
    scan();
    rd(v);
    chk("R4 displaced channel alerted", 32'(v), 32'h010);
    initiate();
    rd(v);
    scan(); scan();
    chk("R3 reinitiate recaptures", 32'(alert_bits), 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) ang_src[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan();
    t_basic();
    t_neg();
    t_wrap();
    t_zero();
    t_no_init();
    t_sticky();
    t_irq();
    t_reinit();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule